// File: doc/BRIEF.md
# Clocked Serial Transceiver (Master, Full Duplex)

This block moves bytes over a three-wire clocked serial link and acts as the link master. The host sees four registers. They set the operating mode and the clock divider, pass one byte of transmit data, return the last received byte, and report four flags: `tx_empty`, `rx_full`, `tx_done` and `rx_overrun`. Frames are 8 bits and are sent most significant bit first. A transmit byte waits in a one-entry holding register and then moves into the shift register. The received byte comes back through that same shift register.

The host picks transmit-only, receive-only, or both directions at once. In receive-only mode the block clocks in byte after byte for as long as it is enabled. In the modes with transmit, every write to the data register starts one frame. The block enforces a strict session discipline. A mode change between two non-idle modes is refused. Leaving the idle mode is refused while any completion or error flag is still set. An overrun stops all traffic until the host clears it.

A one-cycle interrupt pulse marks each byte that lands in the receive register.

Top module: `sync_serial_xcvr`

Register select `host_addr`:
- 0 is the mode register. Bit 0 enables transmit and bit 1 enables receive.
- 1 holds the divider value N.
- 2 is the status register. Bit 0 is `tx_empty`, bit 1 is `rx_full`, bit 2 is `tx_done` and bit 3 is `rx_overrun`. Writing a 1 to bit 2 or bit 3 clears that flag.
- 3 is the data port. A write loads transmit data and a read returns receive data.

## Requirements
- R1: A data write (address 3) while transmit is enabled and `tx_empty`=1 stores the byte, clears `tx_empty` and starts a frame. A data write while `tx_empty`=0 or while transmit is disabled is ignored.
- R2: `tx_empty` returns to 1 in the cycle the held byte enters the shift register, so a second byte can be written while the first one is still shifting. The two bytes then go out back to back, in the order they were written.
- R3: A completed received byte is stored in the receive register and sets `rx_full` (status bit 1). A host read of address 3 clears `rx_full`.
- R4: Each byte that lands in the receive register produces a `rx_irq_o` pulse exactly one cycle long, and the pulse comes whenever `rx_full` rises.
- R5: If a byte completes while `rx_full`=1, `rx_overrun` (status bit 3) sets and the new byte is discarded, so the receive register keeps its old value. While `rx_overrun`=1 no frame starts. Only a status write with bit 3 set clears it, and reading the data does not.
- R6: `tx_done` (status bit 2) sets when the last bit of a frame has been sent and no transmit byte is waiting. A new data write clears it, and so does a status write with bit 2 set.
- R7: A mode write that would move directly from one non-idle mode to a different non-idle mode is ignored. Moving into or out of mode 0 is allowed.
- R8: A mode write that leaves mode 0 is ignored while any of `tx_done`, `rx_full` or `rx_overrun` is 1.
- R9: The serial clock idles low and has a period of 2*(N+1) system clocks. Each frame has exactly 8 rising edges. Output data changes on the falling edges and input data is sampled on the rising edges, MSB first.
- R10: If a host read of the receive register falls in the same cycle as a byte completion, the new byte is stored, `rx_full` stays 1 and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effect only on address 3) |
| host_addr | input | 2 | Register select |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for the selected register (combinational) |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| rx_irq_o | output | 1 | One-cycle pulse when a received byte lands |

## Verification
The contested cycle is one where the host reads the receive register at the same clock edge that a new byte finishes arriving. The read frees the slot and the completion wants to fill it. The bench runs receive-only traffic and measures the byte period from the first two interrupt pulses. It then times a data read so that the read strobe is high at exactly the edge that completes the third byte. The result is judged from the status register afterwards: `rx_full` must still be 1 and `rx_overrun` must be 0, with the interrupt pulse present.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DIV  = 2'd1,
        REG_STAT = 2'd2,
        REG_DATA = 2'd3
    } reg_sel_e;

    // bit 0 = transmit enable, bit 1 = receive enable
    typedef struct packed {
        logic rx;
        logic tx;
    } mode_t;

    // status layout: bit0 tx_empty, bit1 rx_full, bit2 tx_done, bit3 rx_overrun
    typedef struct packed {
        logic rx_overrun;
        logic tx_done;
        logic rx_full;
        logic tx_empty;
    } flags_t;

    localparam int STAT_W        = 4;
    localparam int CLR_DONE_BIT  = 2;
    localparam int CLR_OVR_BIT   = 3;

    // A direct hop between two different non-idle modes is not allowed
    function automatic logic mode_step_ok(mode_t cur, mode_t nxt);
        return (cur == 2'b00) || (nxt == 2'b00) || (cur == nxt);
    endfunction

    // Leaving idle needs all completion and error flags low
    function automatic logic flags_clean(flags_t f);
        return !(f.tx_done || f.rx_full || f.rx_overrun);
    endfunction

endpackage

// File: rtl/ssx_baud.sv
module ssx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // one tick every div_n+1 cycles while running: a half serial period
    assign tick = run && (cnt == div_n);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ssx_shift.sv
module ssx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] load_data,
    input  logic         tick,
    input  logic         sdi,
    output logic         busy,
    output logic         sclk,
    output logic         sdo,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     shreg;
    logic             samp;
    logic [CNT_W-1:0] bitcnt;
    logic             last_fall;

    assign last_fall = (bitcnt == CNT_W'(W));
    assign done      = busy && tick && sclk && last_fall;
    assign sdo       = shreg[W-1];
    assign rx_byte   = {shreg[W-2:0], samp};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            samp   <= 1'b0;
            bitcnt <= '0;
            sclk   <= 1'b0;
            busy   <= 1'b0;
        end else if (start && !busy) begin
            shreg  <= load_data;
            bitcnt <= '0;
            sclk   <= 1'b0;
            busy   <= 1'b1;
        end else if (busy && tick) begin
            if (!sclk) begin
                // rising edge: sample input
                sclk   <= 1'b1;
                samp   <= sdi;
                bitcnt <= bitcnt + 1'b1;
            end else begin
                // falling edge: shift next bit out, or finish
                sclk <= 1'b0;
                if (last_fall) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= {shreg[W-2:0], samp};
                end
            end
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk) else $error("serial clock high while idle"); // R9

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              sclk_o,
    output logic              sdo_o,
    input  logic              sdi_i,
    output logic              rx_irq_o
);
    reg_sel_e          sel;
    mode_t             mode, wmode;
    flags_t            flags;
    logic [DIV_W-1:0]  div_n;
    logic [DATA_W-1:0] tdr, rdr, load_data, rx_byte;
    logic              cur_tx, cur_rx, irq_q;
    logic              busy, tick, done, start;
    logic              ctrl_wr, div_wr, stat_wr, tdr_wr, rdr_rd, mode_ok;
    logic              land, ovr, fin;

    assign sel     = reg_sel_e'(host_addr);
    assign wmode   = mode_t'(host_wdata[1:0]);
    assign ctrl_wr = host_wr && (sel == REG_CTRL);
    assign div_wr  = host_wr && (sel == REG_DIV);
    assign stat_wr = host_wr && (sel == REG_STAT);
    assign tdr_wr  = host_wr && (sel == REG_DATA) && mode.tx && flags.tx_empty;
    assign rdr_rd  = host_rd && (sel == REG_DATA);
    assign mode_ok = mode_step_ok(mode, wmode) &&
                     !((mode == 2'b00) && (wmode != 2'b00) && !flags_clean(flags));

    // transmit modes start on pending data; receive-only runs continuously
    assign start     = (mode != 2'b00) && !busy && !flags.rx_overrun &&
                       (mode.tx ? !flags.tx_empty : 1'b1);
    assign load_data = mode.tx ? tdr : '1;

    // completion outcomes; a same-cycle read frees the receive slot
    assign land = done && cur_rx && (!flags.rx_full || rdr_rd);
    assign ovr  = done && cur_rx && flags.rx_full && !rdr_rd;
    assign fin  = done && cur_tx && flags.tx_empty && !tdr_wr;

    ssx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst   (rst),
        .run   (busy),
        .div_n (div_n),
        .tick  (tick)
    );

    ssx_shift #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load_data (load_data),
        .tick      (tick),
        .sdi       (sdi_i),
        .busy      (busy),
        .sclk      (sclk_o),
        .sdo       (sdo_o),
        .done      (done),
        .rx_byte   (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= 2'b00;
            div_n  <= '0;
            tdr    <= '0;
            rdr    <= '0;
            flags  <= '{rx_overrun: 1'b0, tx_done: 1'b0, rx_full: 1'b0, tx_empty: 1'b1};
            cur_tx <= 1'b0;
            cur_rx <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= land;
            if (start) begin
                cur_tx <= mode.tx;
                cur_rx <= mode.rx;
            end
            if (ctrl_wr && mode_ok) mode  <= wmode;
            if (div_wr)             div_n <= host_wdata[DIV_W-1:0];
            if (tdr_wr)             tdr   <= host_wdata;

            if (start && mode.tx)   flags.tx_empty <= 1'b1;
            else if (tdr_wr)        flags.tx_empty <= 1'b0;

            if (land) begin
                rdr           <= rx_byte;
                flags.rx_full <= 1'b1;
            end else if (rdr_rd) begin
                flags.rx_full <= 1'b0;
            end

            if (ovr)                                      flags.rx_overrun <= 1'b1;
            else if (stat_wr && host_wdata[CLR_OVR_BIT])  flags.rx_overrun <= 1'b0;

            if (fin)                                                   flags.tx_done <= 1'b1;
            else if (tdr_wr || (stat_wr && host_wdata[CLR_DONE_BIT]))  flags.tx_done <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (sel)
            REG_CTRL: host_rdata[1:0]        = mode;
            REG_DIV:  host_rdata[DIV_W-1:0]  = div_n;
            REG_STAT: host_rdata[STAT_W-1:0] = flags;
            REG_DATA: host_rdata             = rdr;
        endcase
    end

    assign rx_irq_o = irq_q;

    AST_MODE_VIA_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |-> ((mode == 2'b00) || ($past(mode) == 2'b00)))
        else $error("direct mode hop"); // R7

    AST_ENABLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (($past(mode) == 2'b00) && (mode != 2'b00)) |->
        (!$past(flags.tx_done) && !$past(flags.rx_full) && !$past(flags.rx_overrun)))
        else $error("enabled with flags set"); // R8

    AST_NO_START_IN_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(flags.rx_overrun))
        else $error("frame started during overrun"); // R5

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(flags.rx_overrun) &&
         !($past(host_wr) && ($past(host_addr) == 2'd2) && $past(host_wdata[CLR_OVR_BIT])))
        |-> flags.rx_overrun)
        else $error("overrun cleared without host clear"); // R5

    AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && cur_tx) |-> flags.tx_empty)
        else $error("holding register not freed on load"); // R2

    AST_IRQ_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.rx_full) |-> rx_irq_o)
        else $error("no interrupt on receive"); // R4

endmodule

// File: tb/tb_sync_serial_xcvr.sv
`timescale 1ns/1ps
module tb_sync_serial_xcvr;
    import ssx_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       sclk, sdo, sdi, irq;
    logic [1:0] sdi_sel = 2'd0;   // 0 loopback, 1 inverted loopback, 2 forced
    logic       sdi_force = 1'b0;

    always #2 clk = ~clk;

    assign sdi = (sdi_sel == 2'd0) ? sdo : (sdi_sel == 2'd1) ? ~sdo : sdi_force;

    sync_serial_xcvr #(.DATA_W(8), .DIV_W(8)) dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sclk_o(sclk), .sdo_o(sdo), .sdi_i(sdi), .rx_irq_o(irq)
    );

    int n_chk = 0, n_fail = 0;

    // observers
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic       prev_sclk = 1'b0, prev_irq = 1'b0;
    int         edges = 0, last_rise = 0, rise_gap = 0, sclk_hi = 0;
    int         irq_cnt = 0, irq_hi = 0, irq_at = 0, irq_prev_at = 0;
    logic [7:0] cap = 8'd0;
    always @(negedge clk) begin
        if (sclk && !prev_sclk) begin
            edges     = edges + 1;
            rise_gap  = cyc - last_rise;
            last_rise = cyc;
            cap       = {cap[6:0], sdo};
        end
        prev_sclk = sclk;
        if (sclk) sclk_hi = sclk_hi + 1;
        if (irq) begin
            irq_hi = irq_hi + 1;
            if (!prev_irq) begin
                irq_cnt     = irq_cnt + 1;
                irq_prev_at = irq_at;
                irq_at      = cyc;
            end
        end
        prev_irq = irq;
    end

    // {inverted loopback, transmit byte, expected received byte}
    localparam logic [16:0] VEC [0:3] = '{
        {1'b0, 8'hA5, 8'hA5},
        {1'b1, 8'h3C, 8'hC3},
        {1'b0, 8'h00, 8'h00},
        {1'b1, 8'hFF, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_bit(input int b, input logic v, input string tag);
        logic [7:0] s;
        s = 8'd0;
        for (int k = 0; k < 4000; k++) begin
            rd(REG_STAT, s);
            if (s[b] === v) break;
        end
        if (s[b] !== v) chk(tag, 32'(s[b]), 32'(v));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        int base, p, target, e0, h0, i0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(REG_STAT, d); chk("R1 reset status", d, 8'h01);
        rd(REG_CTRL, d); chk("R7 reset mode", d, 8'h00);
        chk("R9 reset sclk", sclk, 1'b0);
        chk("R4 reset irq", irq, 1'b0);

        // full duplex vectors
        wr(REG_DIV, 8'd1);
        wr(REG_CTRL, 8'd3);
        i0 = irq_cnt; h0 = irq_hi;
        for (int v = 0; v < 4; v++) begin
            sdi_sel = VEC[v][16] ? 2'd1 : 2'd0;
            wr(REG_DATA, VEC[v][15:8]);
            wait_bit(1, 1'b1, "R1 frame did not complete");
            rd(REG_DATA, d); chk("R3 received byte", d, VEC[v][7:0]);
            rd(REG_STAT, d); chk("R3 rx_full cleared by read", d[1], 1'b0);
        end
        chk("R4 pulse count", irq_cnt - i0, 4);
        chk("R4 pulse width", irq_hi - h0, 4);
        rd(REG_STAT, d); chk("R6 done after last frame", d, 8'h05);
        wr(REG_STAT, 8'h04);
        rd(REG_STAT, d); chk("R6 host clear of done", d, 8'h01);

        // back-to-back writes
        sdi_sel = 2'd0;
        wr(REG_DATA, 8'h81);
        rd(REG_STAT, d); chk("R2 holding reg freed on load", d[0], 1'b1);
        wr(REG_DATA, 8'h42);
        rd(REG_STAT, d); chk("R1 write clears tx_empty", d[0], 1'b0);
        wr(REG_DATA, 8'h99);   // ignored: holding register full
        wait_bit(1, 1'b1, "R2 first byte missing");
        rd(REG_DATA, d); chk("R2 first byte order", d, 8'h81);
        wait_bit(1, 1'b1, "R2 second byte missing");
        rd(REG_DATA, d); chk("R2 second byte order", d, 8'h42);
        repeat (100) @(negedge clk);
        rd(REG_STAT, d); chk("R1 write while full ignored", d, 8'h05);
        wr(REG_STAT, 8'h04);

        // mode discipline
        wr(REG_CTRL, 8'd1);
        rd(REG_CTRL, d); chk("R7 duplex to tx-only ignored", d, 8'h03);
        wr(REG_CTRL, 8'd0);
        rd(REG_CTRL, d); chk("R7 to idle allowed", d, 8'h00);
        wr(REG_CTRL, 8'd1);
        rd(REG_CTRL, d); chk("R7 idle to tx-only allowed", d, 8'h01);
        wr(REG_CTRL, 8'd2);
        rd(REG_CTRL, d); chk("R7 tx-only to rx-only ignored", d, 8'h01);

        // serial timing, tx-only
        wr(REG_DIV, 8'd2);
        e0 = edges;
        wr(REG_DATA, 8'hA5);
        wait_bit(2, 1'b1, "R6 done never set");
        chk("R9 rising edges per frame", edges - e0, 8);
        chk("R9 MSB-first output", cap, 8'hA5);
        chk("R9 clock period", rise_gap, 6);
        chk("R9 idle low after frame", sclk, 1'b0);
        rd(REG_STAT, d); chk("R6 done, no rx in tx-only", d, 8'h05);
        wr(REG_DATA, 8'h5A);
        rd(REG_STAT, d); chk("R6 data write clears done", d[2], 1'b0);
        wait_bit(2, 1'b1, "R6 done never set again");
        wr(REG_CTRL, 8'd0);
        wr(REG_CTRL, 8'd1);
        rd(REG_CTRL, d); chk("R8 enable refused with done set", d, 8'h00);
        wr(REG_STAT, 8'h04);
        wr(REG_CTRL, 8'd1);
        rd(REG_CTRL, d); chk("R8 enable after clear", d, 8'h01);
        wr(REG_CTRL, 8'd0);

        // overrun, rx-only
        wr(REG_DIV, 8'd1);
        sdi_sel = 2'd2; sdi_force = 1'b0;
        wr(REG_CTRL, 8'd2);
        wait_bit(1, 1'b1, "R3 rx-only byte missing");
        sdi_force = 1'b1;
        wait_bit(3, 1'b1, "R5 overrun never set");
        rd(REG_STAT, d); chk("R5 status in overrun", d, 8'h0B);
        h0 = sclk_hi;
        repeat (100) @(negedge clk);
        chk("R5 no clock during overrun", sclk_hi - h0, 0);
        rd(REG_DATA, d); chk("R5 discarded byte, old kept", d, 8'h00);
        rd(REG_STAT, d); chk("R5 read does not clear overrun", d, 8'h09);
        h0 = sclk_hi;
        repeat (60) @(negedge clk);
        chk("R5 still frozen after read", sclk_hi - h0, 0);
        wr(REG_STAT, 8'h08);
        repeat (20) @(negedge clk);
        chk("R5 traffic resumes after clear", (sclk_hi - h0) > 0, 1);
        wr(REG_CTRL, 8'd0);
        repeat (80) @(negedge clk);
        rd(REG_DATA, d);
        rd(REG_STAT, d); chk("R5 clean after drain", d, 8'h01);

        // same-cycle read and completion
        sdi_force = 1'b1;
        base = irq_cnt;
        wr(REG_CTRL, 8'd2);
        for (int k = 0; k < 2000 && irq_cnt < base + 1; k++) @(negedge clk);
        rd(REG_DATA, d); chk("R3 rx-only data", d, 8'hFF);
        for (int k = 0; k < 2000 && irq_cnt < base + 2; k++) @(negedge clk);
        p = irq_at - irq_prev_at;
        target = irq_at + p - 1;
        for (int k = 0; k < 2000 && cyc < target; k++) @(negedge clk);
        host_rd = 1'b1; host_addr = REG_DATA;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
        chk("R10 interrupt on coincident byte", irq, 1'b1);
        rd(REG_STAT, d); chk("R10 full kept, no overrun", d, 8'h03);
        wr(REG_CTRL, 8'd0);
        repeat (80) @(negedge clk);

        summary();
        $finish;
    end

endmodule